// File: doc/BRIEF.md
# DMA ECC Error Capture Register

This block keeps a record of ECC faults found on DMA traffic. Two event channels feed it, one for uncorrectable faults and one for correctable faults. Each channel carries the direction, a byte mask, the physical address and a block-operation flag. The uncorrectable channel also carries a translation-fault flag, and the correctable channel carries an 8-bit syndrome. Each class has its own 64-bit status word. Both classes share one fault-address word.

The first fault of a class that arrives while that class has no primary flag set is taken as primary. It sets a primary flag and loads the detail fields and the shared address. A fault that arrives while a primary flag is still set only raises a secondary flag. This keeps the detail of the first fault intact until software acknowledges it.

Software reads the words through a small offset-addressed register port. It clears flags by writing ones. Each class drives a level interrupt that stays high while any of its flags is set.

Top module: `dma_ecc_errlog`

## Requirements
- R1: After reset, both status words, the address word, both interrupts and the read data of every offset are zero.
- R2: An uncorrectable fault taken as primary is visible one cycle after the event. It sets bit 62 for a read or bit 61 for a write, and bit 56 if its translation flag is set. It loads the byte mask into bits 47:32, address bits 5:3 into bits 31:29 and the block flag into bit 23. It loads the zero-extended address into the address word.
- R3: A correctable fault taken as primary sets bit 62 for a read or bit 61 for a write. It loads the syndrome into bits 55:48, plus the same mask, offset and block fields as R2. It also loads the address word. The correctable word never sets bits 57 or 56.
- R4: While any primary bit of a class is set (62, 61, and for uncorrectable also 56), a new fault of that class sets only bit 59 for a read or bit 58 for a write. An uncorrectable fault with its translation flag also sets bit 57. Bits 55:23 of that class and the address word are left as they were.
- R5: A write to offset 0x30 (uncorrectable) or 0x40 (correctable) clears each flag bit written as 1. Flag bits written as 0, and all other bits, stay unchanged.
- R6: Clears take effect before a fault in the same cycle is classified. Once every primary bit of a class is clear, the next fault of that class is again captured as primary and reloads the detail fields and the address.
- R7: The address word reads the same at offset 0x38 and at its alias 0x48. Writes to either offset are ignored.
- R8: Each class interrupt is high exactly while at least one flag bit (62, 61, 59, 58, 57, 56) of that class is set.
- R9: When both classes capture a primary fault in the same cycle, the address word takes the uncorrectable address.
- R10: A read at any offset other than 0x30, 0x38, 0x40 or 0x48 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ue_valid | input | 1 | Uncorrectable fault event this cycle |
| ue_write | input | 1 | Uncorrectable fault was a DMA write (0 = read) |
| ue_xlat | input | 1 | Uncorrectable fault came with a translation fault |
| ue_bmask | input | 16 | Byte mask of the uncorrectable access |
| ue_addr | input | AW | Physical address of the uncorrectable access |
| ue_blk | input | 1 | Uncorrectable access was a block operation |
| ce_valid | input | 1 | Correctable fault event this cycle |
| ce_write | input | 1 | Correctable fault was a DMA write (0 = read) |
| ce_bmask | input | 16 | Byte mask of the correctable access |
| ce_addr | input | AW | Physical address of the correctable access |
| ce_synd | input | 8 | ECC syndrome of the correctable fault |
| ce_blk | input | 1 | Correctable access was a block operation |
| reg_wen | input | 1 | Register write strobe |
| reg_ofs | input | OW | Register offset for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_ofs |
| ue_status | output | 64 | Uncorrectable status word |
| ce_status | output | 64 | Correctable status word |
| fault_addr | output | 64 | Shared fault-address word |
| ue_irq | output | 1 | Uncorrectable interrupt level |
| ce_irq | output | 1 | Correctable interrupt level |

## Verification
The assertions assume that the event and register inputs are known values on every clock edge once reset is released, and that valid, write and clear strobes last exactly one cycle each. The interrupt assertions also assume that flags only rise through an event and only fall through a clear. The stimulus changes every input just after the falling edge. It keeps random offsets within the mapped set plus one unmapped offset. It mixes random clears with events, so that clears, aliased reads and same-cycle faults of both classes all occur alongside the directed cases.

// File: rtl/ecc_errlog_pkg.sv
`timescale 1ns/1ps
package ecc_errlog_pkg;

  // Flag positions inside a status word
  localparam int BIT_PRD = 62;
  localparam int BIT_PWR = 61;
  localparam int BIT_SRD = 59;
  localparam int BIT_SWR = 58;
  localparam int BIT_SXL = 57;
  localparam int BIT_PXL = 56;

  // Detail field positions
  localparam int SYN_LO = 48;
  localparam int BM_LO  = 32;
  localparam int DW_LO  = 29;
  localparam int BLK_B  = 23;

  typedef struct packed {
    logic        write;
    logic        xlat;
    logic [15:0] bmask;
    logic [2:0]  dw;
    logic [7:0]  synd;
    logic        blk;
  } ecc_evt_t;

  function automatic logic [63:0] flag_bits(input bit has_xlat);
    logic [63:0] r;
    r = '0;
    r[BIT_PRD] = 1'b1;
    r[BIT_PWR] = 1'b1;
    r[BIT_SRD] = 1'b1;
    r[BIT_SWR] = 1'b1;
    r[BIT_SXL] = has_xlat;
    r[BIT_PXL] = has_xlat;
    return r;
  endfunction

  function automatic logic [63:0] prim_bits(input bit has_xlat);
    logic [63:0] r;
    r = '0;
    r[BIT_PRD] = 1'b1;
    r[BIT_PWR] = 1'b1;
    r[BIT_PXL] = has_xlat;
    return r;
  endfunction

  function automatic logic [63:0] detail_bits();
    logic [63:0] r;
    r = '0;
    r[55:23] = '1;
    return r;
  endfunction

  function automatic logic [2:0] dword_ofs(input logic [5:0] low_addr);
    return low_addr[5:3];
  endfunction

  function automatic logic [63:0] pack_detail(input ecc_evt_t e, input bit has_synd);
    logic [63:0] r;
    r = '0;
    r[BM_LO +: 16] = e.bmask;
    r[DW_LO +: 3]  = e.dw;
    r[BLK_B]       = e.blk;
    if (has_synd) r[SYN_LO +: 8] = e.synd;
    return r;
  endfunction

endpackage

// File: rtl/ecc_class_rec.sv
`timescale 1ns/1ps
module ecc_class_rec
  import ecc_errlog_pkg::*;
#(
  parameter bit HAS_XLAT = 1'b1,
  parameter bit HAS_SYND = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  ecc_evt_t    ev,
  input  logic        clr_en,
  input  logic [63:0] clr_bits,
  output logic [63:0] status,
  output logic        took_primary,
  output logic        irq
);

  localparam logic [63:0] FLAGS  = flag_bits(HAS_XLAT);
  localparam logic [63:0] PRIM   = prim_bits(HAS_XLAT);
  localparam logic [63:0] DETAIL = detail_bits();

  logic [63:0] stat_q, kept, setv, det, stat_d;
  logic        xl_hit;

  generate
    if (HAS_XLAT) begin : g_xlat
      assign xl_hit = ev.xlat;
    end else begin : g_noxlat
      assign xl_hit = 1'b0 & ev.xlat;
    end
  endgenerate

  always_comb begin
    kept = clr_en ? (stat_q & ~(clr_bits & FLAGS)) : stat_q;
    took_primary = ev_valid && ((kept & PRIM) == '0);
    setv = '0;
    if (ev_valid) begin
      if (took_primary) begin
        setv[ev.write ? BIT_PWR : BIT_PRD] = 1'b1;
        if (xl_hit) setv[BIT_PXL] = 1'b1;
      end else begin
        setv[ev.write ? BIT_SWR : BIT_SRD] = 1'b1;
        if (xl_hit) setv[BIT_SXL] = 1'b1;
      end
    end
    det = pack_detail(ev, HAS_SYND);
    stat_d = took_primary ? ((kept & ~DETAIL) | det | setv) : (kept | setv);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
  assign irq    = |(stat_q & FLAGS);

  // R4
  sec_keeps_detail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !took_primary) |=> ((status & DETAIL) == $past(status & DETAIL)));

  // R4
  sec_needs_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !took_primary) |-> ((status & PRIM) != '0));

  // R2
  prim_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_primary |=> (status[DW_LO +: 3] == $past(ev.dw)));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_valid));

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_en));

endmodule

// File: rtl/ecc_far_latch.sv
`timescale 1ns/1ps
module ecc_far_latch #(
  parameter int AW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ue_take,
  input  logic [AW-1:0] ue_addr,
  input  logic          ce_take,
  input  logic [AW-1:0] ce_addr,
  output logic [63:0]   far
);

  localparam int PAD = 64 - AW;

  logic [63:0] far_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       far_q <= '0;
    else if (ue_take) far_q <= {{PAD{1'b0}}, ue_addr};
    else if (ce_take) far_q <= {{PAD{1'b0}}, ce_addr};
  end

  assign far = far_q;

  // R9
  ue_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_take && ce_take) |=> (far[AW-1:0] == $past(ue_addr)));

  // R4
  far_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ue_take && !ce_take) |=> $stable(far));

endmodule

// File: rtl/ecc_reg_port.sv
`timescale 1ns/1ps
module ecc_reg_port #(
  parameter int          OW        = 8,
  parameter int unsigned UE_OFS    = 32'h30,
  parameter int unsigned FAR_OFS   = 32'h38,
  parameter int unsigned CE_OFS    = 32'h40,
  parameter int unsigned FAR_ALIAS = 32'h48
) (
  input  logic          reg_wen,
  input  logic [OW-1:0] reg_ofs,
  input  logic [63:0]   ue_status,
  input  logic [63:0]   ce_status,
  input  logic [63:0]   fault_addr,
  output logic          ue_clr_en,
  output logic          ce_clr_en,
  output logic [63:0]   reg_rdata
);

  localparam logic [OW-1:0] A_UE  = UE_OFS[OW-1:0];
  localparam logic [OW-1:0] A_CE  = CE_OFS[OW-1:0];
  localparam logic [OW-1:0] A_FAR = FAR_OFS[OW-1:0];
  localparam logic [OW-1:0] A_ALI = FAR_ALIAS[OW-1:0];

  assign ue_clr_en = reg_wen && (reg_ofs == A_UE);
  assign ce_clr_en = reg_wen && (reg_ofs == A_CE);

  always_comb begin
    if (reg_ofs == A_UE)                             reg_rdata = ue_status;
    else if (reg_ofs == A_CE)                        reg_rdata = ce_status;
    else if (reg_ofs == A_FAR || reg_ofs == A_ALI)   reg_rdata = fault_addr;
    else                                             reg_rdata = '0;
  end

endmodule

// File: rtl/dma_ecc_errlog.sv
`timescale 1ns/1ps
module dma_ecc_errlog
  import ecc_errlog_pkg::*;
#(
  parameter int          AW        = 34,
  parameter int          OW        = 8,
  parameter int unsigned UE_OFS    = 32'h30,
  parameter int unsigned FAR_OFS   = 32'h38,
  parameter int unsigned CE_OFS    = 32'h40,
  parameter int unsigned FAR_ALIAS = 32'h48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ue_valid,
  input  logic          ue_write,
  input  logic          ue_xlat,
  input  logic [15:0]   ue_bmask,
  input  logic [AW-1:0] ue_addr,
  input  logic          ue_blk,
  input  logic          ce_valid,
  input  logic          ce_write,
  input  logic [15:0]   ce_bmask,
  input  logic [AW-1:0] ce_addr,
  input  logic [7:0]    ce_synd,
  input  logic          ce_blk,
  input  logic          reg_wen,
  input  logic [OW-1:0] reg_ofs,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  output logic [63:0]   ue_status,
  output logic [63:0]   ce_status,
  output logic [63:0]   fault_addr,
  output logic          ue_irq,
  output logic          ce_irq
);

  ecc_evt_t ue_ev, ce_ev;
  logic     ue_take, ce_take, ue_clr_en, ce_clr_en;

  always_comb begin
    ue_ev       = '0;
    ue_ev.write = ue_write;
    ue_ev.xlat  = ue_xlat;
    ue_ev.bmask = ue_bmask;
    ue_ev.dw    = dword_ofs(ue_addr[5:0]);
    ue_ev.blk   = ue_blk;
    ce_ev       = '0;
    ce_ev.write = ce_write;
    ce_ev.bmask = ce_bmask;
    ce_ev.dw    = dword_ofs(ce_addr[5:0]);
    ce_ev.synd  = ce_synd;
    ce_ev.blk   = ce_blk;
  end

  ecc_reg_port #(
    .OW(OW), .UE_OFS(UE_OFS), .FAR_OFS(FAR_OFS),
    .CE_OFS(CE_OFS), .FAR_ALIAS(FAR_ALIAS)
  ) u_port (
    .reg_wen   (reg_wen),
    .reg_ofs   (reg_ofs),
    .ue_status (ue_status),
    .ce_status (ce_status),
    .fault_addr(fault_addr),
    .ue_clr_en (ue_clr_en),
    .ce_clr_en (ce_clr_en),
    .reg_rdata (reg_rdata)
  );

  ecc_class_rec #(.HAS_XLAT(1'b1), .HAS_SYND(1'b0)) u_ue (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ue_valid),
    .ev          (ue_ev),
    .clr_en      (ue_clr_en),
    .clr_bits    (reg_wdata),
    .status      (ue_status),
    .took_primary(ue_take),
    .irq         (ue_irq)
  );

  ecc_class_rec #(.HAS_XLAT(1'b0), .HAS_SYND(1'b1)) u_ce (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ce_valid),
    .ev          (ce_ev),
    .clr_en      (ce_clr_en),
    .clr_bits    (reg_wdata),
    .status      (ce_status),
    .took_primary(ce_take),
    .irq         (ce_irq)
  );

  ecc_far_latch #(.AW(AW)) u_far (
    .clk    (clk),
    .rst_n  (rst_n),
    .ue_take(ue_take),
    .ue_addr(ue_addr),
    .ce_take(ce_take),
    .ce_addr(ce_addr),
    .far    (fault_addr)
  );

  // R3
  ce_no_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_status[57:56] == 2'b00));

endmodule

// File: tb/sim_dma_ecc_errlog.sv
`timescale 1ns/1ps
module sim_dma_ecc_errlog;

  localparam int AW = 34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ue_valid = 0, ue_write = 0, ue_xlat = 0, ue_blk = 0;
  logic [15:0]   ue_bmask = '0;
  logic [AW-1:0] ue_addr = '0;
  logic          ce_valid = 0, ce_write = 0, ce_blk = 0;
  logic [15:0]   ce_bmask = '0;
  logic [AW-1:0] ce_addr = '0;
  logic [7:0]    ce_synd = '0;
  logic          reg_wen = 0;
  logic [7:0]    reg_ofs = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata, ue_status, ce_status, fault_addr;
  logic          ue_irq, ce_irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_ue = '0, m_ce = '0, m_far = '0;

  always #4 clk = ~clk;

  dma_ecc_errlog u0 (
    .clk(clk), .rst_n(rst_n),
    .ue_valid(ue_valid), .ue_write(ue_write), .ue_xlat(ue_xlat),
    .ue_bmask(ue_bmask), .ue_addr(ue_addr), .ue_blk(ue_blk),
    .ce_valid(ce_valid), .ce_write(ce_write), .ce_bmask(ce_bmask),
    .ce_addr(ce_addr), .ce_synd(ce_synd), .ce_blk(ce_blk),
    .reg_wen(reg_wen), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ue_status(ue_status), .ce_status(ce_status),
    .fault_addr(fault_addr), .ue_irq(ue_irq), .ce_irq(ce_irq)
  );

  function automatic logic [63:0] w1c_set(input bit is_ue);
    return is_ue ? 64'h6F00_0000_0000_0000 : 64'h6C00_0000_0000_0000;
  endfunction

  function automatic logic [63:0] first_set(input bit is_ue);
    return is_ue ? 64'h6100_0000_0000_0000 : 64'h6000_0000_0000_0000;
  endfunction

  function automatic logic [63:0] after_clr(input logic [63:0] cur, input bit is_ue,
                                            input logic en, input logic [63:0] wd);
    return en ? (cur & ~(wd & w1c_set(is_ue))) : cur;
  endfunction

  function automatic bit is_first(input logic [63:0] cur, input bit is_ue,
                                  input logic en, input logic [63:0] wd);
    return (after_clr(cur, is_ue, en, wd) & first_set(is_ue)) == 64'd0;
  endfunction

  function automatic logic [63:0] predict(input logic [63:0] cur, input bit is_ue,
      input logic v, input logic wr, input logic xl, input logic [15:0] bm,
      input logic [AW-1:0] a, input logic [7:0] sy, input logic bk,
      input logic en, input logic [63:0] wd);
    logic [63:0] c;
    c = after_clr(cur, is_ue, en, wd);
    if (v) begin
      if ((c & first_set(is_ue)) == 64'd0) begin
        c = c & 64'hFF00_0000_007F_FFFF;
        c = c | ({48'd0, bm} << 32) | ({61'd0, a[5:3]} << 29) | ({63'd0, bk} << 23);
        if (!is_ue) c = c | ({56'd0, sy} << 48);
        c = c | (wr ? (64'd1 << 61) : (64'd1 << 62));
        if (is_ue && xl) c = c | (64'd1 << 56);
      end else begin
        c = c | (wr ? (64'd1 << 58) : (64'd1 << 59));
        if (is_ue && xl) c = c | (64'd1 << 57);
      end
    end
    return c;
  endfunction

  function automatic logic [63:0] expect_read(input logic [7:0] o);
    case (o)
      8'h30: return m_ue;
      8'h40: return m_ce;
      8'h38, 8'h48: return m_far;
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    ue_valid = 0; ce_valid = 0; reg_wen = 0; reg_wdata = '0;
  endtask

  // Advance one clock with the inputs as set, then compare all outputs
  task automatic tick(input string tag);
    logic [63:0] n_ue, n_ce, n_far;
    logic        ut, ct, uclr, cclr;
    uclr = reg_wen && reg_ofs == 8'h30;
    cclr = reg_wen && reg_ofs == 8'h40;
    ut = ue_valid && is_first(m_ue, 1'b1, uclr, reg_wdata);
    ct = ce_valid && is_first(m_ce, 1'b0, cclr, reg_wdata);
    n_ue = predict(m_ue, 1'b1, ue_valid, ue_write, ue_xlat, ue_bmask, ue_addr, 8'd0,
                   ue_blk, uclr, reg_wdata);
    n_ce = predict(m_ce, 1'b0, ce_valid, ce_write, 1'b0, ce_bmask, ce_addr, ce_synd,
                   ce_blk, cclr, reg_wdata);
    n_far = ut ? {30'd0, ue_addr} : (ct ? {30'd0, ce_addr} : m_far);
    @(posedge clk);
    @(negedge clk);
    m_ue = n_ue; m_ce = n_ce; m_far = n_far;
    idle();
    chk(tag, "ue_status", ue_status, m_ue);
    chk(tag, "ce_status", ce_status, m_ce);
    chk(tag, "fault_addr", fault_addr, m_far);
    // R8
    chk("R8", "ue_irq", {63'd0, ue_irq}, {63'd0, (m_ue & w1c_set(1'b1)) != 0});
    chk("R8", "ce_irq", {63'd0, ce_irq}, {63'd0, (m_ce & w1c_set(1'b0)) != 0});
  endtask

  task automatic rd(input string tag, input logic [7:0] o, input logic [63:0] exp);
    reg_wen = 0; reg_ofs = o; #1;
    chk(tag, "reg_rdata", reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] o, input logic [63:0] d);
    reg_wen = 1; reg_ofs = o; reg_wdata = d;
  endtask

  task automatic ue_ev(input logic w, input logic x, input logic [15:0] b,
                       input logic [AW-1:0] a, input logic k);
    ue_valid = 1; ue_write = w; ue_xlat = x; ue_bmask = b; ue_addr = a; ue_blk = k;
  endtask

  task automatic ce_ev(input logic w, input logic [15:0] b, input logic [AW-1:0] a,
                       input logic [7:0] s, input logic k);
    ce_valid = 1; ce_write = w; ce_bmask = b; ce_addr = a; ce_synd = s; ce_blk = k;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ofs_set [5];
    ofs_set[0] = 8'h30; ofs_set[1] = 8'h38; ofs_set[2] = 8'h40;
    ofs_set[3] = 8'h48; ofs_set[4] = 8'h50;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", "ue_status", ue_status, 64'd0);
    chk("R1", "ce_status", ce_status, 64'd0);
    chk("R1", "fault_addr", fault_addr, 64'd0);
    chk("R1", "irqs", {62'd0, ue_irq, ce_irq}, 64'd0);
    rd("R1", 8'h38, 64'd0);

    // R2 uncorrectable primary read with translation flag
    ue_ev(0, 1, 16'hA5C3, 34'h2_1234_5678, 1);
    tick("R2");
    chk("R2", "ue_word", ue_status, 64'h4100_A5C3_E080_0000);
    chk("R2", "addr", fault_addr, 64'h0000_0002_1234_5678);

    // R4 later write fault only flags secondary
    ue_ev(1, 0, 16'h1111, 34'h0_0000_0008, 0);
    tick("R4");
    chk("R4", "ue_word", ue_status, 64'h4500_A5C3_E080_0000);
    chk("R4", "addr", fault_addr, 64'h0000_0002_1234_5678);
    ue_ev(0, 1, 16'h2222, 34'h0_0000_0010, 0);
    tick("R4");
    chk("R4", "ue_xlat2", ue_status, 64'h4F00_A5C3_E080_0000);

    // R7 R10 reads
    rd("R5", 8'h30, 64'h4F00_A5C3_E080_0000);
    rd("R7", 8'h38, 64'h0000_0002_1234_5678);
    rd("R7", 8'h48, 64'h0000_0002_1234_5678);
    rd("R10", 8'h50, 64'd0);
    rd("R10", 8'h00, 64'd0);

    // R5 writing zeros clears nothing, non-flag ones do nothing
    wr(8'h30, 64'h90FF_FFFF_FFFF_FFFF);
    tick("R5");
    chk("R5", "ue_zero_wr", ue_status, 64'h4F00_A5C3_E080_0000);
    // R7 address word ignores writes
    wr(8'h38, 64'hFFFF_FFFF_FFFF_FFFF);
    tick("R7");
    wr(8'h48, 64'd0);
    tick("R7");
    chk("R7", "far_wr", fault_addr, 64'h0000_0002_1234_5678);

    // R5 clear primary bits only
    wr(8'h30, 64'h4100_0000_0000_0000);
    tick("R5");
    chk("R5", "ue_part", ue_status, 64'h0E00_A5C3_E080_0000);
    chk("R8", "ue_irq_sec", {63'd0, ue_irq}, 64'd1);

    // R6 next fault captured as primary again
    ue_ev(1, 0, 16'h0F0F, 34'h1_0000_0020, 0);
    tick("R6");
    chk("R6", "ue_word", ue_status, 64'h2E00_0F0F_8000_0000);
    chk("R6", "addr", fault_addr, 64'h0000_0001_0000_0020);

    // R6 clear and fault in the same cycle
    wr(8'h30, 64'hFFFF_FFFF_FFFF_FFFF);
    ue_ev(0, 0, 16'h00AA, 34'h0_0000_0018, 1);
    tick("R6");
    chk("R6", "same_cycle", ue_status, 64'h4000_00AA_6080_0000);
    wr(8'h30, 64'hFFFF_FFFF_FFFF_FFFF);
    tick("R8");
    chk("R8", "ue_irq_off", {63'd0, ue_irq}, 64'd0);

    // R3 correctable primary with syndrome
    ce_ev(1, 16'h00FF, 34'h3_0000_0028, 8'h3C, 0);
    tick("R3");
    chk("R3", "ce_word", ce_status, 64'h203C_00FF_A000_0000);
    chk("R3", "addr", fault_addr, 64'h0000_0003_0000_0028);
    rd("R3", 8'h40, 64'h203C_00FF_A000_0000);
    ce_ev(0, 16'hFFFF, 34'h0, 8'h77, 1);
    tick("R4");
    chk("R4", "ce_sec", ce_status, 64'h283C_00FF_A000_0000);
    wr(8'h40, 64'hFFFF_FFFF_FFFF_FFFF);
    tick("R5");

    // R9 both classes capture together
    ue_ev(0, 0, 16'h1234, 34'h0_AAAA_0000, 0);
    ce_ev(0, 16'h4321, 34'h0_5555_0000, 8'h01, 0);
    tick("R9");
    chk("R9", "addr", fault_addr, 64'h0000_0000_AAAA_0000);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0)
        ue_ev($urandom % 2, $urandom % 2, 16'($urandom), {2'($urandom), 32'($urandom)},
              $urandom % 2);
      if ($urandom % 4 == 0)
        ce_ev($urandom % 2, 16'($urandom), {2'($urandom), 32'($urandom)}, 8'($urandom),
              $urandom % 2);
      reg_ofs = ofs_set[$urandom % 5];
      if ($urandom % 5 == 0) begin
        reg_wen = 1;
        reg_wdata = {32'($urandom), 32'($urandom)};
      end
      tick("R6");
      if (i % 5 == 0) begin
        logic [7:0] o;
        o = ofs_set[$urandom % 5];
        rd("R7", o, expect_read(o));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule